// File: doc/BRIEF.md
# Intensity Ramp Sequencer

This block sets the firing level handed to a phase-angle firing timer so that lamp brightness moves gradually between zero and a chosen peak. A start pulse captures the ramp settings: the peak level, how many fire events each step lasts, and the ramp direction. After that, every fire event from the firing timer is counted. One fire event occurs per mains half cycle. When the programmed number of events has been seen at the current level, the level moves one step toward the end point.

An upward ramp (brighten) begins at level zero and climbs to the peak. A downward ramp (dim) begins at the peak and falls to zero. When the end point is reached, a done flag rises and the level stays where it is until the next start. The total ramp time is the peak level multiplied by the events per step, counted in half cycles. The firing timer itself sits outside this block.

Top module: `intensity_ramp`

## Requirements
- R1: While `rst` is high at a clock edge, `level` becomes 0 and `done` becomes 0.
- R2: The cycle after `start` is high, `level` equals 0 if `ramp_dir` was 1 (brighten), or equals `max_level` if `ramp_dir` was 0 (dim).
- R3: While a ramp is running, `level` moves by exactly one step, the cycle after every Nth accepted `fire` pulse, where N is the effective events-per-step value. It does not change on any other cycle.
- R4: A `fires_per_step` value of 0 acts as 1, so the level steps on every fire event.
- R5: A brighten ramp raises `done` together with `level` reaching the peak, after exactly peak × N fire events.
- R6: A dim ramp raises `done` together with `level` reaching 0, after exactly peak × N fire events.
- R7: Once `done` is 1, further `fire` pulses leave `level` and `done` unchanged until the next `start`.
- R8: `level` never exceeds the peak captured at the last `start`. A peak of 0 gives `level` 0 and `done` 1 the cycle after `start`.
- R9: `fire` pulses before the first `start` after reset are ignored, so `level` stays 0 and `done` stays 0.
- R10: A `start` during a running ramp restarts it from its new initial level with the event count cleared. A `fire` in the same cycle as `start` is not counted.
- R11: Changes on `max_level`, `fires_per_step` and `ramp_dir` between start pulses have no effect on the running ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures the settings and begins a ramp |
| ramp_dir | input | 1 | 1 = brighten (count up), 0 = dim (count down) |
| max_level | input | LEVEL_W | Peak level of the ramp |
| fires_per_step | input | FIRE_W | Fire events per level step (0 treated as 1) |
| fire | input | 1 | One-cycle pulse per fire event from the firing timer |
| level | output | LEVEL_W | Current firing level, registered |
| done | output | 1 | Ramp has reached its end point, registered |

## Verification
The bench builds the block with its default 4-bit level and 4-bit events-per-step widths. At those widths every combination of peak (0 to 15), events per step (0 to 15) and direction can be ramped from start to finish. The bench compares the level and done flag after each fire event against closed-form values. The inputs are driven to their complements right after every start, so the latching of the settings is exercised on every ramp. Separate directed runs cover fire pulses before any start, a restart partway through a ramp with a fire in the same cycle, and holding after the end point.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic {
    RAMP_DIM = 1'b0,
    RAMP_UP  = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/ramp_cfg_latch.sv
module ramp_cfg_latch #(
  parameter int LEVEL_W = 4,
  parameter int FIRE_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [LEVEL_W-1:0]  max_in,
  input  logic [FIRE_W-1:0]   fps_in,
  input  ramp_pkg::ramp_dir_e dir_in,
  output logic [LEVEL_W-1:0]  max_q,
  output logic [FIRE_W-1:0]   fps_q,
  output ramp_pkg::ramp_dir_e dir_q
);
  localparam logic [FIRE_W-1:0] FPS_ONE = FIRE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= '0;
      fps_q <= FPS_ONE;
      dir_q <= ramp_pkg::RAMP_UP;
    end else if (load) begin
      max_q <= max_in;
      // R4: zero events per step acts as one
      fps_q <= (fps_in == '0) ? FPS_ONE : fps_in;
      dir_q <= dir_in;
    end
  end

  // R4
  fps_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    fps_q != '0);
endmodule

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
  parameter int FIRE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              fire_en,
  input  logic [FIRE_W-1:0] limit,
  output logic              step
);
  logic [FIRE_W-1:0] cnt;

  assign step = fire_en && (cnt == limit - FIRE_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (fire_en)  cnt <= step ? '0 : cnt + FIRE_W'(1);
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
endmodule

// File: rtl/ramp_level_unit.sv
module ramp_level_unit #(
  parameter int LEVEL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  ramp_pkg::ramp_dir_e dir_in,
  input  logic [LEVEL_W-1:0]  max_in,
  input  logic                step,
  input  ramp_pkg::ramp_dir_e dir_q,
  input  logic [LEVEL_W-1:0]  max_q,
  output logic [LEVEL_W-1:0]  level,
  output logic                done,
  output logic                running
);
  logic               active;
  logic [LEVEL_W-1:0] nxt;

  assign running = active && !done;

  // R8: saturate at both ends
  always_comb begin
    if (dir_q == ramp_pkg::RAMP_UP)
      nxt = (level < max_q) ? level + LEVEL_W'(1) : max_q;
    else
      nxt = (level != '0) ? level - LEVEL_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= '0;
      done   <= 1'b0;
      active <= 1'b0;
    end else if (start) begin
      level  <= (dir_in == ramp_pkg::RAMP_UP) ? '0 : max_in;
      done   <= (max_in == '0);
      active <= 1'b1;
    end else if (step) begin
      level <= nxt;
      done  <= (dir_q == ramp_pkg::RAMP_UP) ? (nxt == max_q) : (nxt == '0);
    end
  end

  // R8
  level_le_max_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> level <= max_q);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(level)));
  // R3
  no_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !step) |=> $stable(level));
  // R5 R6
  done_endpoint_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (level == ((dir_q == ramp_pkg::RAMP_UP) ? max_q : '0)));
endmodule

// File: rtl/intensity_ramp.sv
module intensity_ramp #(
  parameter int LEVEL_W = 4,
  parameter int FIRE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               ramp_dir,
  input  logic [LEVEL_W-1:0] max_level,
  input  logic [FIRE_W-1:0]  fires_per_step,
  input  logic               fire,
  output logic [LEVEL_W-1:0] level,
  output logic               done
);
  logic [LEVEL_W-1:0]  max_q;
  logic [FIRE_W-1:0]   fps_q;
  ramp_pkg::ramp_dir_e dir_q;
  ramp_pkg::ramp_dir_e dir_in;
  logic                running;
  logic                fire_en;
  logic                step;

  assign dir_in = ramp_dir ? ramp_pkg::RAMP_UP : ramp_pkg::RAMP_DIM;
  // R9 R10: count only while a ramp runs, never in a start cycle
  assign fire_en = fire && running && !start;

  ramp_cfg_latch #(.LEVEL_W(LEVEL_W), .FIRE_W(FIRE_W)) u_cfg (
    .clk(clk), .rst(rst), .load(start),
    .max_in(max_level), .fps_in(fires_per_step), .dir_in(dir_in),
    .max_q(max_q), .fps_q(fps_q), .dir_q(dir_q)
  );

  ramp_step_counter #(.FIRE_W(FIRE_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(start), .fire_en(fire_en),
    .limit(fps_q), .step(step)
  );

  ramp_level_unit #(.LEVEL_W(LEVEL_W)) u_lvl (
    .clk(clk), .rst(rst), .start(start), .dir_in(dir_in),
    .max_in(max_level), .step(step), .dir_q(dir_q), .max_q(max_q),
    .level(level), .done(done), .running(running)
  );
endmodule

// File: tb/sim_intensity_ramp.sv
`timescale 1ns/1ps
module sim_intensity_ramp;
  localparam int LW = 4;
  localparam int FW = 4;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ramp_dir = 1'b1;
  logic [LW-1:0] max_level = '0;
  logic [FW-1:0] fires_per_step = '0;
  logic fire = 1'b0;
  logic [LW-1:0] level;
  logic done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  intensity_ramp #(.LEVEL_W(LW), .FIRE_W(FW)) u0 (
    .clk(clk), .rst(rst), .start(start), .ramp_dir(ramp_dir),
    .max_level(max_level), .fires_per_step(fires_per_step), .fire(fire),
    .level(level), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input bit d, input int m, input int f, input bit with_fire);
    @(negedge clk);
    start = 1'b1; ramp_dir = d;
    max_level = LW'(m); fires_per_step = FW'(f); fire = with_fire;
    @(negedge clk);
    start = 1'b0; fire = 1'b0;
    // R11: scramble settings after capture
    ramp_dir = ~d; max_level = ~LW'(m); fires_per_step = ~FW'(f);
  endtask

  task automatic do_fire();
    @(negedge clk); fire = 1'b1;
    @(negedge clk); fire = 1'b0;
  endtask

  function automatic int exp_level(bit d, int m, int fe, int n);
    int k;
    k = n / fe;
    if (k > m) k = m;
    return d ? k : m - k;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 level", level, 0);
    chk("R1 done", done, 0);
    rst = 1'b0;
    // R9
    repeat (4) do_fire();
    chk("R9 level", level, 0);
    chk("R9 done", done, 0);

    // Sweep every peak, events-per-step and direction
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 16; m++) begin
        for (int f = 0; f < 16; f++) begin
          int fe;
          int total;
          fe = (f == 0) ? 1 : f;
          total = m * fe;
          do_start(d[0], m, f, 1'b0);
          chk(d ? "R2 up init" : "R2 dim init", level, d ? 0 : m);
          chk("R8 init done", done, (m == 0) ? 1 : 0);
          for (int n = 1; n <= total; n++) begin
            do_fire();
            if (n == total)
              chk(d ? "R5 end level" : "R6 end level", level, exp_level(d[0], m, fe, n));
            else if (f == 0)
              chk("R4 level", level, exp_level(d[0], m, fe, n));
            else
              chk("R3 R11 level", level, exp_level(d[0], m, fe, n));
            chk(d ? "R5 done" : "R6 done", done, (n >= total) ? 1 : 0);
          end
          // R7
          repeat (2) do_fire();
          chk("R7 hold level", level, d ? m : 0);
          chk("R7 hold done", done, 1);
          chk("R8 level le peak", (level <= m) ? 1 : 0, 1);
        end
      end
    end

    // R10: restart mid-ramp with a fire in the start cycle
    do_start(1'b1, 5, 2, 1'b0);
    repeat (3) do_fire();
    chk("R10 pre level", level, 1);
    do_start(1'b0, 9, 3, 1'b1);
    chk("R10 restart level", level, 9);
    chk("R10 restart done", done, 0);
    repeat (2) do_fire();
    chk("R10 count cleared", level, 9);
    do_fire();
    chk("R10 first step", level, 8);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule